// File: doc/BRIEF.md
# Activity-Sensing Auto-Sleep Controller

This block decides when a small logic core may drop into a low-power standby and when it must come back, using nothing but observed signal activity. It samples a bus of monitored lines (dedicated inputs, bidirectional pins, the clock line and internal feedbacks) on a free-running sampling clock. It treats any difference between the current sample and the previous one as activity. When a programmable number of consecutive samples shows no change, the controller freezes the core's output values and output enables in a holding register, drives those frozen values, and raises a sleep indication.

The first sampled change after that wakes the controller. Sleep drops at once. For one cycle the output-valid flag stays low, which models the slower first response after standby. The live outputs are then passed through again, and the idle count restarts from zero. No command enters or leaves sleep. A supply-good indication, brought in through a synchronizer, gates the whole block. Until it is seen high, every output enable stays low (pins tri-stated) and valid stays low. Losing it in any state returns the block to this power-up condition.

Top module: `actpd_ctrl`

## Requirements
- R1: While the synchronized supply-good level is low, including straight after reset, `out_en_o` and `out_data_o` are all zero and `valid_o` and `sleep_o` are low.
- R2: `supply_ok` passes through SYNC_STAGES flip-flops. After it rises and stays high, `valid_o` is first seen high after exactly SYNC_STAGES+1 sampling edges.
- R3: Activity is any bit of `mon_i` differing from its value at the previous sampling edge. A change on a single bit, including the most significant bit, counts.
- R4: In the running state, `sleep_o` is set at the edge that ends the QUIET_CYC-th consecutive cycle without activity. It is seen after exactly QUIET_CYC quiet cycles.
- R5: Every detected change resets the idle count, so changes spaced QUIET_CYC cycles apart never lead to sleep.
- R6: In the running state, `out_data_o` and `out_en_o` follow `out_data_i` and `out_en_i` in the same cycle, `valid_o` is high and `sleep_o` is low.
- R7: On sleep entry the live data and enables present at that edge are captured. While asleep and during the wake-up cycle, the outputs show the captured values whatever the live inputs do.
- R8: A change while asleep clears `sleep_o` at the next edge. `valid_o` is then low for exactly one cycle before running resumes. The idle count restarts after that cycle.
- R9: While asleep, `valid_o` stays high, because the held outputs are valid.
- R10: A drop of the synchronized supply-good level in any state returns the block to the R1 condition at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok | input | 1 | Asynchronous supply-good level |
| mon_i | input | MON_W | Monitored lines |
| out_data_i | input | OUT_W | Live output values from the core |
| out_en_i | input | OUT_W | Live output enables from the core |
| out_data_o | output | OUT_W | Output values toward the pins |
| out_en_o | output | OUT_W | Output enables toward the pins (0 = high impedance) |
| sleep_o | output | 1 | Standby active |
| valid_o | output | 1 | Outputs are settled and usable |

## Verification
The bench builds the block with QUIET_CYC=4, MON_W=10, OUT_W=6 and SYNC_STAGES=2. A quiet window that is not the default puts the idle counter's saturation value and its off-by-one boundary under test: it separates QUIET_CYC-1 quiet cycles, which must never sleep, from QUIET_CYC quiet cycles, which must. The narrow buses let random stimulus reach single-bit changes on the top monitored bit and enable patterns of every shape during sleep. Two synchronizer stages give a power-up latency short enough that repeated supply drops fit inside the random run.

// File: rtl/actpd_pkg.sv
package actpd_pkg;

    typedef enum logic [1:0] {
        ST_PWRUP = 2'd0,
        ST_RUN   = 2'd1,
        ST_SLEEP = 2'd2,
        ST_WAKE  = 2'd3
    } pd_state_e;

    typedef enum logic [1:0] {
        OSEL_OFF  = 2'd0,
        OSEL_LIVE = 2'd1,
        OSEL_HELD = 2'd2
    } osel_e;

endpackage

// File: rtl/actpd_sync.sv
module actpd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
    } sync_reg_t;

    sync_reg_t r_d, r_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb r_d.sh = async_i;
        end else begin : g_chain
            always_comb r_d.sh = {r_q.sh[STAGES-2:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sync_o = r_q.sh[STAGES-1];
endmodule

// File: rtl/actpd_detect.sv
module actpd_detect #(
    parameter int W     = 20,
    parameter int QUIET = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] mon_i,
    input  logic         clr_i,
    output logic         act_o,
    output logic         quiet_o
);
    localparam int CNT_W = (QUIET > 1) ? $clog2(QUIET) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(QUIET - 1);

    typedef struct packed {
        logic [W-1:0]     mon;
        logic [CNT_W-1:0] cnt;
    } det_reg_t;

    det_reg_t r_d, r_q;
    logic [W-1:0] diff;

    // per-line change flags
    generate
        for (genvar b = 0; b < W; b++) begin : g_diff
            assign diff[b] = mon_i[b] ^ r_q.mon[b];
        end
    endgenerate

    assign act_o   = |diff;
    assign quiet_o = !act_o && (r_q.cnt == CNT_LAST);

    always_comb begin
        r_d     = r_q;
        r_d.mon = mon_i;
        if (clr_i || act_o)          r_d.cnt = '0;
        else if (r_q.cnt != CNT_LAST) r_d.cnt = r_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/actpd_hold.sv
module actpd_hold
    import actpd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_i,
    input  osel_e        sel_i,
    input  logic [W-1:0] data_i,
    input  logic [W-1:0] en_i,
    output logic [W-1:0] data_o,
    output logic [W-1:0] en_o
);
    typedef struct packed {
        logic [W-1:0] data;
        logic [W-1:0] en;
    } hold_reg_t;

    hold_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (cap_i) begin
            r_d.data = data_i;
            r_d.en   = en_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        unique case (sel_i)
            OSEL_LIVE: begin data_o = data_i;  en_o = en_i;  end
            OSEL_HELD: begin data_o = r_q.data; en_o = r_q.en; end
            default:   begin data_o = '0;       en_o = '0;    end
        endcase
    end
endmodule

// File: rtl/actpd_ctrl.sv
module actpd_ctrl
    import actpd_pkg::*;
#(
    parameter int MON_W       = 20,
    parameter int OUT_W       = 8,
    parameter int QUIET_CYC   = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             supply_ok,
    input  logic [MON_W-1:0] mon_i,
    input  logic [OUT_W-1:0] out_data_i,
    input  logic [OUT_W-1:0] out_en_i,
    output logic [OUT_W-1:0] out_data_o,
    output logic [OUT_W-1:0] out_en_o,
    output logic             sleep_o,
    output logic             valid_o
);
    typedef struct packed {
        pd_state_e st;
    } fsm_reg_t;

    fsm_reg_t r_d, r_q;
    logic     pwr_ok;
    logic     act, quiet;
    logic     cap;
    osel_e    osel;

    actpd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (supply_ok),
        .sync_o  (pwr_ok)
    );

    actpd_detect #(.W(MON_W), .QUIET(QUIET_CYC)) u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .mon_i   (mon_i),
        .clr_i   (r_q.st != ST_RUN),
        .act_o   (act),
        .quiet_o (quiet)
    );

    // next-state logic
    always_comb begin
        r_d = r_q;
        cap = 1'b0;
        if (!pwr_ok) begin
            r_d.st = ST_PWRUP;
        end else begin
            unique case (r_q.st)
                ST_PWRUP: r_d.st = ST_RUN;
                ST_RUN: if (quiet) begin
                    r_d.st = ST_SLEEP;
                    cap    = 1'b1;
                end
                ST_SLEEP: if (act) r_d.st = ST_WAKE;
                default:  r_d.st = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_PWRUP};
        else        r_q <= r_d;
    end

    always_comb begin
        unique case (r_q.st)
            ST_RUN:             osel = OSEL_LIVE;
            ST_SLEEP, ST_WAKE:  osel = OSEL_HELD;
            default:            osel = OSEL_OFF;
        endcase
    end

    actpd_hold #(.W(OUT_W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_i  (cap),
        .sel_i  (osel),
        .data_i (out_data_i),
        .en_i   (out_en_i),
        .data_o (out_data_o),
        .en_o   (out_en_o)
    );

    assign sleep_o = (r_q.st == ST_SLEEP);
    assign valid_o = (r_q.st == ST_RUN) || (r_q.st == ST_SLEEP);
endmodule

// File: rtl/actpd_chk.sv
module actpd_chk #(
    parameter int MON_W = 20,
    parameter int OUT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwr_ok,
    input logic [MON_W-1:0] mon_i,
    input logic [OUT_W-1:0] out_data_i,
    input logic [OUT_W-1:0] out_en_i,
    input logic [OUT_W-1:0] out_data_o,
    input logic [OUT_W-1:0] out_en_o,
    input logic             sleep_o,
    input logic             valid_o
);
    // R1
    pwrup_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> (out_en_o == '0 && out_data_o == '0 && !valid_o && !sleep_o));

    // R4
    quiet_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_o) |-> ($past(mon_i) == $past(mon_i, 2)));

    // R6
    live_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !sleep_o) |-> (out_data_o == out_data_i && out_en_o == out_en_i));

    // R7
    held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_o && $past(sleep_o)) |-> ($stable(out_data_o) && $stable(out_en_o)));

    // R8
    wake_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_o && mon_i != $past(mon_i)) |=> !sleep_o);

    // R8
    wake_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep_o) |-> !valid_o);

    // R9
    sleep_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_o |-> valid_o);
endmodule

bind actpd_ctrl actpd_chk #(.MON_W(MON_W), .OUT_W(OUT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_ok     (pwr_ok),
    .mon_i      (mon_i),
    .out_data_i (out_data_i),
    .out_en_i   (out_en_i),
    .out_data_o (out_data_o),
    .out_en_o   (out_en_o),
    .sleep_o    (sleep_o),
    .valid_o    (valid_o)
);

// File: tb/sim_actpd_ctrl.sv
module sim_actpd_ctrl;
    localparam int MW = 10;
    localparam int OW = 6;
    localparam int Q  = 4;
    localparam int SS = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0;
    logic [MW-1:0] mon = '0;
    logic [OW-1:0] ld = '0, le = '0;
    logic [OW-1:0] od, oe;
    logic sleep_o, valid_o;

    actpd_ctrl #(.MON_W(MW), .OUT_W(OW), .QUIET_CYC(Q), .SYNC_STAGES(SS)) u0 (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .mon_i(mon),
        .out_data_i(ld), .out_en_i(le), .out_data_o(od), .out_en_o(oe),
        .sleep_o(sleep_o), .valid_o(valid_o)
    );

    always #5 clk = ~clk;

    int checks = 0, errors = 0;
    bit done = 0;

    // pending stimulus, applied by step()
    logic nx_rst = 1'b0, nx_sup = 1'b0;
    logic [MW-1:0] nx_mon = '0;
    logic [OW-1:0] nx_ld = '0, nx_le = '0;

    // reference model state: 0 powerup, 1 run, 2 sleep, 3 wake
    int m_st = 0;
    int m_cnt = 0;
    logic [SS-1:0] m_sync = '0;
    logic [MW-1:0] m_monq = '0;
    logic [OW-1:0] m_hd = '0, m_he = '0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [OW-1:0] exp_data();
        case (m_st)
            1: return nx_ld;
            2, 3: return m_hd;
            default: return '0;
        endcase
    endfunction

    function automatic logic [OW-1:0] exp_en();
        case (m_st)
            1: return nx_le;
            2, 3: return m_he;
            default: return '0;
        endcase
    endfunction

    task automatic model_edge();
        logic act, pwr;
        if (!nx_rst) begin
            m_st = 0; m_cnt = 0; m_sync = '0; m_monq = '0; m_hd = '0; m_he = '0;
            return;
        end
        act = (nx_mon != m_monq);
        pwr = m_sync[SS-1];
        case (m_st)
            0: if (pwr) begin m_st = 1; m_cnt = 0; end
            1: if (!pwr) m_st = 0;
               else if (!act && m_cnt == Q-1) begin m_st = 2; m_hd = nx_ld; m_he = nx_le; end
               else m_cnt = act ? 0 : m_cnt + 1;
            2: if (!pwr) m_st = 0; else if (act) m_st = 3;
            default: if (!pwr) m_st = 0; else begin m_st = 1; m_cnt = 0; end
        endcase
        if (m_st != 1) m_cnt = 0;
        m_monq = nx_mon;
        m_sync = {m_sync[SS-2:0], nx_sup};
    endtask

    task automatic step();
        string t;
        @(negedge clk);
        rst_n = nx_rst; supply_ok = nx_sup; mon = nx_mon; ld = nx_ld; le = nx_le;
        #1;
        case (m_st)
            0: t = "R1";
            1: t = "R6";
            2: t = "R7";
            default: t = "R8";
        endcase
        chk({t, " data"}, od, exp_data());
        chk({t, " enable"}, oe, exp_en());
        chk((m_st == 2) ? "R9 valid" : {t, " valid"}, valid_o, (m_st == 1 || m_st == 2));
        chk({t, " sleep"}, sleep_o, (m_st == 2));
        model_edge();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        bit saw;
        void'($urandom(32'd4242));

        // reset state (R1)
        repeat (3) step();
        nx_rst = 1'b1;
        step();

        // R2: power-up latency
        nx_sup = 1'b1;
        n = 0;
        for (int i = 0; i < 20; i++) begin
            step();
            if (valid_o) break;
            n++;
        end
        chk("R2 latency", n, SS + 1);

        // R4: exactly Q quiet cycles to sleep
        nx_ld = 6'h2A; nx_le = 6'h15;
        nx_mon = nx_mon ^ 10'h001;
        step();
        n = 0;
        for (int i = 0; i < 20; i++) begin
            step();
            if (sleep_o) break;
            n++;
        end
        chk("R4 quiet count", n, Q);

        // R7: live inputs scrambled while asleep
        for (int i = 0; i < 6; i++) begin
            nx_ld = OW'($urandom); nx_le = OW'($urandom);
            step();
        end
        chk("R7 held data", od, 6'h2A);

        // R3 and R8: top-bit change wakes, one-cycle gap
        nx_mon = nx_mon ^ (10'h1 << (MW - 1));
        step();
        step();
        chk("R3 top bit wake sleep", sleep_o, 1'b0);
        chk("R8 wake gap valid", valid_o, 1'b0);
        step();
        chk("R8 resume valid", valid_o, 1'b1);

        // R5: change every Q cycles never sleeps
        saw = 0;
        for (int i = 0; i < 40; i++) begin
            if (i % Q == 0) nx_mon = nx_mon ^ 10'h004;
            step();
            if (sleep_o) saw = 1;
        end
        chk("R5 no sleep", saw, 1'b0);

        // R10: supply loss while asleep
        repeat (Q + 2) step();
        chk("R10 asleep before drop", sleep_o, 1'b1);
        nx_sup = 1'b0;
        repeat (SS + 1) step();
        step();
        chk("R10 enables off", oe, '0);
        chk("R10 valid low", valid_o, 1'b0);
        nx_sup = 1'b1;

        // random activity with varying density
        for (int i = 0; i < 4000; i++) begin
            int rate;
            rate = ((i / 500) % 2 == 1) ? 2 : 9;
            if ($urandom % rate == 0) nx_mon = nx_mon ^ (10'h1 << ($urandom % MW));
            nx_ld = OW'($urandom);
            nx_le = OW'($urandom);
            if ($urandom % 600 == 0) nx_sup = !nx_sup;
            if (!nx_sup && $urandom % 20 == 0) nx_sup = 1'b1;
            step();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule